// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block turns one I2C master command into the ordered run of bus phases a bit-level SCL/SDA shifter carries out. A command names the target, says whether the target uses a 7-bit or 10-bit address, gives the direction and a byte count, and carries two chaining flags. One flag skips the opening start and address phases. The other keeps the bus after the data phase. Write bytes come in through a valid/ready pair and read bytes leave through another. Each phase goes to the bit layer as a held request with an operation code and waits for a one-cycle completion pulse. That pulse returns the slave's acknowledge bit, a received byte, and an arbitration-loss flag.

The sequencer decides between an initial start and a repeated start from whether it already owns the bus. It encodes 10-bit headers and sets the master acknowledge bit for each read byte. It handles target refusals, lost arbitration and a bus that stays busy for too long. It also makes sure a 10-bit read never begins without a repeated start. When a command ends, a status code is posted and held until the next command is taken.

Top module: `i2c_txn_seq`

## Requirements
- R1: Bit-layer operation codes are 1 start, 2 repeated start, 3 write byte, 4 read byte, 5 stop. A command that needs a start while the block owns the bus issues code 2 at once. Otherwise the block waits for `bus_busy` to be low before it issues code 1.
- R2: If `bus_busy` stays high for IDLE_LIMIT cycles while the block waits to start, the command ends with status 5 (busy, retry) and no bit-layer operation is issued.
- R3: In 7-bit mode the address phase is one written byte: address bits 6:0 in bits 7:1, and bit 0 set to 1 for a read.
- R4: In 10-bit mode the first byte is 11110, then address bits 9:8, then the read bit. For a write, a second byte with address bits 7:0 follows. For a read, only the first byte is sent.
- R5: A 10-bit read that would need an initial start ends at once with status 4 (invalid) and touches no bus phase.
- R6: A NACK on any address byte stops the bus and ends with status 1 (no device). Ownership is released.
- R7: In a write, a NACK on a data byte that is not the last stops the bus and ends with status 2 (I/O error). A NACK on the final data byte still ends with status 0 (ok).
- R8: In a read, bytes are returned on the read port in order. `bit_nack` is 0 for every read-byte request except the last one, which carries 1. This also holds when the command reads a single byte.
- R9: Arbitration loss reported with any completion ends the command at once with status 3. No stop is issued and ownership is cleared.
- R10: After a stop, the block waits up to STOP_LIMIT busy cycles for `bus_busy` to clear. If it does not clear, the status is 6 (timeout). Ownership is cleared either way.
- R11: The no-start flag skips the start and address phases. The no-stop flag ends the command with the bus still owned.
- R12: A zero-length command performs only the start/address and stop phases its flags enable.
- R13: `sts_done` and `sts_code` stay unchanged from the end of a command until the next command is accepted. Accepting a command clears `sts_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | 10 | Target address |
| cmd_ten | input | 1 | 1 = 10-bit address |
| cmd_read | input | 1 | 1 = read |
| cmd_len | input | LEN_W | Data byte count |
| cmd_nostart | input | 1 | Skip start and address phases |
| cmd_nostop | input | 1 | Keep the bus after the data phase |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| bit_req | output | 1 | Bit-layer request, held until bit_done |
| bit_op | output | 3 | Bit-layer operation code (R1) |
| bit_wdata | output | 8 | Byte to write |
| bit_nack | output | 1 | Master answers NACK to this read byte |
| bit_done | input | 1 | One-cycle completion pulse |
| bit_rdata | input | 8 | Byte received, valid with bit_done |
| bit_nack_rx | input | 1 | Slave NACKed the written byte, valid with bit_done |
| bit_arb_lost | input | 1 | Arbitration lost, valid with bit_done |
| bus_busy | input | 1 | Bus-busy indication |
| sts_done | output | 1 | Command finished, status valid |
| sts_code | output | 3 | Result code |
| owns_bus | output | 1 | Block currently holds the bus |

## Verification
The bench builds the block with IDLE_LIMIT = 12, STOP_LIMIT = 16 and LEN_W = 4, and keeps 10-bit support enabled. The short limits mean both wait windows can be driven to expiry, or held just short of it, in a few dozen cycles instead of sixty-five thousand. The 4-bit length is enough for every byte count the scenarios use. With 10-bit support on, the header encoding, the rejection of a 10-bit read without a repeated start, and the legal repeated-start 10-bit read can all be tested.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [2:0] {
      BOP_NONE   = 3'd0,
      BOP_START  = 3'd1,
      BOP_RSTART = 3'd2,
      BOP_WRITE  = 3'd3,
      BOP_READ   = 3'd4,
      BOP_STOP   = 3'd5
   } bit_op_e;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_NODEV   = 3'd1,
      RES_IOERR   = 3'd2,
      RES_ARBLOST = 3'd3,
      RES_INVALID = 3'd4,
      RES_BUSY    = 3'd5,
      RES_TIMEOUT = 3'd6
   } result_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT_IDLE,
      S_START,
      S_ADDR1,
      S_ADDR2,
      S_DSEL,
      S_WFETCH,
      S_WXFER,
      S_RXFER,
      S_RHAND,
      S_STOP,
      S_STOP_WAIT
   } seq_state_e;

   localparam logic [4:0] HDR10_TAG = 5'b11110;

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr #(
   parameter bit ADDR10_EN = 1'b1
) (
   input  logic [9:0] addr,
   input  logic       ten,
   input  logic       rd,
   output logic [7:0] first_byte,
   output logic [7:0] second_byte,
   output logic       two_bytes
);
   import i2c_seq_pkg::*;

   logic [7:0] seven_byte;
   assign seven_byte = {addr[6:0], rd};

   generate
      if (ADDR10_EN) begin : g_ten
         always_comb begin
            if (ten) begin
               first_byte  = {HDR10_TAG, addr[9:8], rd};
               second_byte = addr[7:0];
               two_bytes   = ~rd;
            end else begin
               first_byte  = seven_byte;
               second_byte = 8'h00;
               two_bytes   = 1'b0;
            end
         end
      end else begin : g_seven
         logic unused_ten;
         assign unused_ten  = ten ^ (|addr[9:7]);
         assign first_byte  = seven_byte;
         assign second_byte = 8'h00;
         assign two_bytes   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2c_seq_wait.sv
module i2c_seq_wait #(
   parameter int LIMIT = 65535
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic busy,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign expired = run && busy && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!run)               cnt <= '0;
      else if (busy && !expired)   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
   parameter int LEN_W      = 8,
   parameter int IDLE_LIMIT = 65535,
   parameter int STOP_LIMIT = 65536,
   parameter bit ADDR10_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [9:0]       cmd_addr,
   input  logic             cmd_ten,
   input  logic             cmd_read,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             cmd_nostart,
   input  logic             cmd_nostop,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   output logic             bit_req,
   output logic [2:0]       bit_op,
   output logic [7:0]       bit_wdata,
   output logic             bit_nack,
   input  logic             bit_done,
   input  logic [7:0]       bit_rdata,
   input  logic             bit_nack_rx,
   input  logic             bit_arb_lost,
   input  logic             bus_busy,
   output logic             sts_done,
   output logic [2:0]       sts_code,
   output logic             owns_bus
);
   import i2c_seq_pkg::*;

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   generate
      if (LEN_W < 1 || IDLE_LIMIT < 1 || STOP_LIMIT < 1) begin : g_bad_param
         $error("i2c_txn_seq: LEN_W and both wait limits must be at least 1");
      end
   endgenerate

   seq_state_e       st;
   logic             owned;
   logic             done_q;
   result_e          code_q;
   result_e          pend_q;
   logic [LEN_W-1:0] rem_q;
   logic [9:0]       addr_q;
   logic             ten_q;
   logic             rd_q;
   logic             nostop_q;
   logic             rstart_q;
   logic [7:0]       byte_q;
   logic [7:0]       rdat_q;

   logic [7:0] hdr1, hdr2;
   logic       hdr_two;
   logic       idle_exp, stop_exp;
   logic       fin_ok;

   i2c_seq_addr #(.ADDR10_EN(ADDR10_EN)) u_addr (
      .addr        (addr_q),
      .ten         (ten_q),
      .rd          (rd_q),
      .first_byte  (hdr1),
      .second_byte (hdr2),
      .two_bytes   (hdr_two)
   );

   i2c_seq_wait #(.LIMIT(IDLE_LIMIT)) u_idle_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == S_WAIT_IDLE),
      .busy    (bus_busy),
      .expired (idle_exp)
   );

   i2c_seq_wait #(.LIMIT(STOP_LIMIT)) u_stop_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == S_STOP_WAIT),
      .busy    (bus_busy),
      .expired (stop_exp)
   );

   always_comb begin
      bit_req   = 1'b0;
      bit_op    = BOP_NONE;
      bit_wdata = 8'h00;
      unique case (st)
         S_START: begin
            bit_req = 1'b1;
            bit_op  = rstart_q ? BOP_RSTART : BOP_START;
         end
         S_ADDR1: begin
            bit_req   = 1'b1;
            bit_op    = BOP_WRITE;
            bit_wdata = hdr1;
         end
         S_ADDR2: begin
            bit_req   = 1'b1;
            bit_op    = BOP_WRITE;
            bit_wdata = hdr2;
         end
         S_WXFER: begin
            bit_req   = 1'b1;
            bit_op    = BOP_WRITE;
            bit_wdata = byte_q;
         end
         S_RXFER: begin
            bit_req = 1'b1;
            bit_op  = BOP_READ;
         end
         S_STOP: begin
            bit_req = 1'b1;
            bit_op  = BOP_STOP;
         end
         default: ;
      endcase
   end

   assign bit_nack  = (st == S_RXFER) && (rem_q == ONE);
   assign cmd_ready = (st == S_IDLE);
   assign wr_ready  = (st == S_WFETCH);
   assign rd_valid  = (st == S_RHAND);
   assign rd_data   = rdat_q;
   assign sts_done  = done_q;
   assign sts_code  = code_q;
   assign owns_bus  = owned;
   assign fin_ok    = !bus_busy || stop_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         owned    <= 1'b0;
         done_q   <= 1'b0;
         code_q   <= RES_OK;
         pend_q   <= RES_OK;
         rem_q    <= '0;
         addr_q   <= '0;
         ten_q    <= 1'b0;
         rd_q     <= 1'b0;
         nostop_q <= 1'b0;
         rstart_q <= 1'b0;
         byte_q   <= 8'h00;
         rdat_q   <= 8'h00;
      end else if (bit_req && bit_done && bit_arb_lost) begin
         st     <= S_IDLE;
         owned  <= 1'b0;
         done_q <= 1'b1;
         code_q <= RES_ARBLOST;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (cmd_valid) begin
                  addr_q   <= cmd_addr;
                  ten_q    <= cmd_ten;
                  rd_q     <= cmd_read;
                  rem_q    <= cmd_len;
                  nostop_q <= cmd_nostop;
                  rstart_q <= owned;
                  pend_q   <= RES_OK;
                  if (cmd_ten && !ADDR10_EN) begin
                     done_q <= 1'b1;
                     code_q <= RES_INVALID;
                  end else if (cmd_nostart) begin
                     done_q <= 1'b0;
                     st     <= S_DSEL;
                  end else if (owned) begin
                     done_q <= 1'b0;
                     st     <= S_START;
                  end else if (cmd_ten && cmd_read) begin
                     done_q <= 1'b1;
                     code_q <= RES_INVALID;
                  end else begin
                     done_q <= 1'b0;
                     st     <= S_WAIT_IDLE;
                  end
               end
            end
            S_WAIT_IDLE: begin
               if (!bus_busy) begin
                  st <= S_START;
               end else if (idle_exp) begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                  code_q <= RES_BUSY;
               end
            end
            S_START: begin
               if (bit_done) begin
                  owned <= 1'b1;
                  st    <= S_ADDR1;
               end
            end
            S_ADDR1, S_ADDR2: begin
               if (bit_done) begin
                  if (bit_nack_rx) begin
                     pend_q <= RES_NODEV;
                     st     <= S_STOP;
                  end else if (st == S_ADDR1 && hdr_two) begin
                     st <= S_ADDR2;
                  end else begin
                     st <= S_DSEL;
                  end
               end
            end
            S_DSEL: begin
               if (rem_q == '0) begin
                  if (nostop_q) begin
                     st     <= S_IDLE;
                     done_q <= 1'b1;
                     code_q <= RES_OK;
                  end else begin
                     st <= S_STOP;
                  end
               end else if (rd_q) begin
                  st <= S_RXFER;
               end else begin
                  st <= S_WFETCH;
               end
            end
            S_WFETCH: begin
               if (wr_valid) begin
                  byte_q <= wr_data;
                  st     <= S_WXFER;
               end
            end
            S_WXFER: begin
               if (bit_done) begin
                  if (bit_nack_rx && rem_q != ONE) begin
                     pend_q <= RES_IOERR;
                     st     <= S_STOP;
                  end else begin
                     rem_q <= rem_q - ONE;
                     st    <= S_DSEL;
                  end
               end
            end
            S_RXFER: begin
               if (bit_done) begin
                  rdat_q <= bit_rdata;
                  st     <= S_RHAND;
               end
            end
            S_RHAND: begin
               if (rd_ready) begin
                  rem_q <= rem_q - ONE;
                  st    <= S_DSEL;
               end
            end
            S_STOP: begin
               if (bit_done) st <= S_STOP_WAIT;
            end
            S_STOP_WAIT: begin
               if (fin_ok) begin
                  st     <= S_IDLE;
                  owned  <= 1'b0;
                  done_q <= 1'b1;
                  if (pend_q != RES_OK)  code_q <= pend_q;
                  else if (bus_busy)     code_q <= RES_TIMEOUT;
                  else                   code_q <= RES_OK;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic [7:0] rd_data,
   input logic       bit_req,
   input logic [2:0] bit_op,
   input logic [7:0] bit_wdata,
   input logic       bit_done,
   input logic       bit_arb_lost,
   input logic       bus_busy,
   input logic       sts_done,
   input logic [2:0] sts_code,
   input logic       owns_bus
);

   // R1
   start_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bit_req) && bit_op == 3'd1) |-> !$past(bus_busy));

   // R1
   rstart_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && bit_op == 3'd2) |-> owns_bus);

   // R9
   arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && bit_done && bit_arb_lost) |=> (sts_done && sts_code == 3'd3 && !owns_bus && !bit_req));

   // R10
   release_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(owns_bus) |-> sts_done);

   // R13
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_done && !(cmd_valid && cmd_ready)) |=> (sts_done && $stable(sts_code)));

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && !bit_done) |=> (bit_req && $stable(bit_op) && $stable(bit_wdata)));

   // R13
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ready && bit_req));

endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .rd_valid     (rd_valid),
   .rd_ready     (rd_ready),
   .rd_data      (rd_data),
   .bit_req      (bit_req),
   .bit_op       (bit_op),
   .bit_wdata    (bit_wdata),
   .bit_done     (bit_done),
   .bit_arb_lost (bit_arb_lost),
   .bus_busy     (bus_busy),
   .sts_done     (sts_done),
   .sts_code     (sts_code),
   .owns_bus     (owns_bus)
);

// File: tb/i2c_txn_seq_bench.sv
module i2c_txn_seq_bench;

   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [9:0]    cmd_addr = '0;
   logic          cmd_ten = 1'b0;
   logic          cmd_read = 1'b0;
   logic [LW-1:0] cmd_len = '0;
   logic          cmd_nostart = 1'b0;
   logic          cmd_nostop = 1'b0;
   logic          wr_valid = 1'b1;
   logic          wr_ready;
   logic [7:0]    wr_data;
   logic          rd_valid;
   logic          rd_ready = 1'b0;
   logic [7:0]    rd_data;
   logic          bit_req;
   logic [2:0]    bit_op;
   logic [7:0]    bit_wdata;
   logic          bit_nack;
   logic          bit_done = 1'b0;
   logic [7:0]    bit_rdata = 8'h00;
   logic          bit_nack_rx = 1'b0;
   logic          bit_arb_lost = 1'b0;
   logic          bus_busy;
   logic          sts_done;
   logic [2:0]    sts_code;
   logic          owns_bus;

   // slave / bit-layer model state
   logic          ext_busy = 1'b0;
   logic          mdl_busy = 1'b0;
   logic          log_clr = 1'b0;
   int            stop_hold = 3;
   int            stop_left = 0;
   int            nack_at = -1;
   int            arb_at = -1;
   int            dly = 0;
   int            nops = 0;
   int            nrd = 0;
   int            nrx = 0;
   int            wsent = 0;
   logic [2:0]    op_log [16];
   logic [7:0]    byte_log [16];
   logic          nack_log [16];
   logic [7:0]    rx_log [16];

   int n_chk = 0;
   int n_fail = 0;

   assign bus_busy = ext_busy | mdl_busy;
   assign wr_data  = 8'h30 + wsent[7:0];

   always #2.5 clk = ~clk;

   i2c_txn_seq #(
      .LEN_W(LW), .IDLE_LIMIT(12), .STOP_LIMIT(16), .ADDR10_EN(1'b1)
   ) u_i2c_txn_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_ten(cmd_ten), .cmd_read(cmd_read), .cmd_len(cmd_len),
      .cmd_nostart(cmd_nostart), .cmd_nostop(cmd_nostop),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .bit_req(bit_req), .bit_op(bit_op), .bit_wdata(bit_wdata), .bit_nack(bit_nack),
      .bit_done(bit_done), .bit_rdata(bit_rdata), .bit_nack_rx(bit_nack_rx),
      .bit_arb_lost(bit_arb_lost), .bus_busy(bus_busy),
      .sts_done(sts_done), .sts_code(sts_code), .owns_bus(owns_bus)
   );

   always @(negedge clk) rd_ready <= ~rd_ready;

   always @(posedge clk) begin
      bit_done <= 1'b0;
      if (log_clr) begin
         nops <= 0; nrd <= 0; nrx <= 0; wsent <= 0; dly <= 0;
      end else begin
         if (rd_valid && rd_ready) begin
            rx_log[nrx] <= rd_data;
            nrx <= nrx + 1;
         end
         if (wr_valid && wr_ready) wsent <= wsent + 1;
         if (stop_left != 0) begin
            stop_left <= stop_left - 1;
            if (stop_left == 1) mdl_busy <= 1'b0;
         end
         if (bit_req && !bit_done) begin
            if (dly == 1) begin
               dly <= 0;
               bit_done <= 1'b1;
               op_log[nops]   <= bit_op;
               byte_log[nops] <= bit_wdata;
               nack_log[nops] <= bit_nack;
               bit_nack_rx  <= (bit_op == 3'd3) && (nops == nack_at);
               bit_arb_lost <= (nops == arb_at);
               if (bit_op == 3'd4) begin
                  bit_rdata <= 8'hA0 + nrd[7:0];
                  nrd <= nrd + 1;
               end
               if (bit_op == 3'd1) mdl_busy <= 1'b1;
               if (bit_op == 3'd5) stop_left <= stop_hold;
               if (nops == arb_at) mdl_busy <= 1'b0;
               nops <= nops + 1;
            end else begin
               dly <= dly + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic run_cmd(input logic [9:0] a, input logic t, input logic r,
                          input int len, input logic ns, input logic np);
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
      cmd_addr = a; cmd_ten = t; cmd_read = r; cmd_len = LW'(len);
      cmd_nostart = ns; cmd_nostop = np; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!sts_done) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk_eq("R13 reset ready", int'(cmd_ready), 1);
      chk_eq("R13 reset done", int'(sts_done), 0);
      chk_eq("R9 reset owns", int'(owns_bus), 0);
      chk_eq("R1 reset req", int'(bit_req), 0);
   endtask

   task automatic t_write7;
      run_cmd(10'h02A, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      chk_eq("R1 w7 ops", nops, 5);
      chk_eq("R1 w7 start op", int'(op_log[0]), 1);
      chk_eq("R3 w7 addr byte", int'(byte_log[1]), 8'h54);
      chk_eq("R7 w7 data0", int'(byte_log[2]), 8'h30);
      chk_eq("R7 w7 data1", int'(byte_log[3]), 8'h31);
      chk_eq("R10 w7 stop op", int'(op_log[4]), 5);
      chk_eq("R7 w7 status", int'(sts_code), 0);
      chk_eq("R10 w7 owns", int'(owns_bus), 0);
   endtask

   task automatic t_read7;
      run_cmd(10'h051, 1'b0, 1'b1, 3, 1'b0, 1'b0);
      chk_eq("R3 r7 addr byte", int'(byte_log[1]), 8'hA3);
      chk_eq("R8 r7 ops", nops, 6);
      chk_eq("R8 r7 op rd", int'(op_log[3]), 4);
      chk_eq("R8 r7 ack0", int'(nack_log[2]), 0);
      chk_eq("R8 r7 ack1", int'(nack_log[3]), 0);
      chk_eq("R8 r7 nack last", int'(nack_log[4]), 1);
      chk_eq("R8 r7 rx count", nrx, 3);
      chk_eq("R8 r7 rx0", int'(rx_log[0]), 8'hA0);
      chk_eq("R8 r7 rx2", int'(rx_log[2]), 8'hA2);
      chk_eq("R8 r7 status", int'(sts_code), 0);
      run_cmd(10'h051, 1'b0, 1'b1, 1, 1'b0, 1'b0);
      chk_eq("R8 r1 nack single", int'(nack_log[2]), 1);
      chk_eq("R8 r1 ops", nops, 4);
   endtask

   task automatic t_write10;
      run_cmd(10'h2B5, 1'b1, 1'b0, 1, 1'b0, 1'b0);
      chk_eq("R4 w10 ops", nops, 5);
      chk_eq("R4 w10 header", int'(byte_log[1]), 8'hF4);
      chk_eq("R4 w10 low byte", int'(byte_log[2]), 8'hB5);
      chk_eq("R4 w10 data", int'(byte_log[3]), 8'h30);
      chk_eq("R4 w10 status", int'(sts_code), 0);
   endtask

   task automatic t_read10_invalid;
      run_cmd(10'h2B5, 1'b1, 1'b1, 1, 1'b0, 1'b0);
      chk_eq("R5 status", int'(sts_code), 4);
      chk_eq("R5 no ops", nops, 0);
      chk_eq("R5 owns", int'(owns_bus), 0);
   endtask

   task automatic t_read10_rstart;
      run_cmd(10'h2B5, 1'b1, 1'b0, 0, 1'b0, 1'b1);
      chk_eq("R12 zero-len nostop ops", nops, 3);
      chk_eq("R11 nostop owns", int'(owns_bus), 1);
      chk_eq("R11 nostop status", int'(sts_code), 0);
      run_cmd(10'h2B5, 1'b1, 1'b1, 1, 1'b0, 1'b0);
      chk_eq("R1 rstart op", int'(op_log[0]), 2);
      chk_eq("R4 r10 header", int'(byte_log[1]), 8'hF5);
      chk_eq("R4 r10 read op", int'(op_log[2]), 4);
      chk_eq("R8 r10 nack", int'(nack_log[2]), 1);
      chk_eq("R4 r10 ops", nops, 4);
      chk_eq("R4 r10 status", int'(sts_code), 0);
      chk_eq("R10 r10 owns", int'(owns_bus), 0);
   endtask

   task automatic t_zero_len;
      run_cmd(10'h011, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      chk_eq("R12 zero ops", nops, 3);
      chk_eq("R12 zero stop", int'(op_log[2]), 5);
      chk_eq("R12 zero status", int'(sts_code), 0);
   endtask

   task automatic t_addr_nack;
      nack_at = 1;
      run_cmd(10'h033, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      nack_at = -1;
      chk_eq("R6 ops", nops, 3);
      chk_eq("R6 stop op", int'(op_log[2]), 5);
      chk_eq("R6 status", int'(sts_code), 1);
      chk_eq("R6 owns", int'(owns_bus), 0);
   endtask

   task automatic t_data_nack;
      nack_at = 2;
      run_cmd(10'h033, 1'b0, 1'b0, 3, 1'b0, 1'b0);
      chk_eq("R7 mid ops", nops, 4);
      chk_eq("R7 mid stop", int'(op_log[3]), 5);
      chk_eq("R7 mid status", int'(sts_code), 2);
      nack_at = 3;
      run_cmd(10'h033, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      nack_at = -1;
      chk_eq("R7 last ops", nops, 5);
      chk_eq("R7 last status", int'(sts_code), 0);
   endtask

   task automatic t_arb;
      arb_at = 1;
      run_cmd(10'h044, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      arb_at = -1;
      chk_eq("R9 status", int'(sts_code), 3);
      chk_eq("R9 ops no stop", nops, 2);
      chk_eq("R9 owns", int'(owns_bus), 0);
   endtask

   task automatic t_idle_wait;
      ext_busy = 1'b1;
      run_cmd(10'h044, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      ext_busy = 1'b0;
      chk_eq("R2 status", int'(sts_code), 5);
      chk_eq("R2 no ops", nops, 0);
      fork
         begin
            ext_busy = 1'b1;
            repeat (8) @(negedge clk);
            ext_busy = 1'b0;
         end
         run_cmd(10'h044, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      join
      chk_eq("R1 waited status", int'(sts_code), 0);
      chk_eq("R1 waited start", int'(op_log[0]), 1);
   endtask

   task automatic t_stop_timeout;
      stop_hold = 40;
      run_cmd(10'h055, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      stop_hold = 3;
      chk_eq("R10 timeout status", int'(sts_code), 6);
      chk_eq("R10 timeout owns", int'(owns_bus), 0);
      repeat (45) @(negedge clk);
   endtask

   task automatic t_nostart;
      run_cmd(10'h066, 1'b0, 1'b0, 1, 1'b0, 1'b1);
      chk_eq("R11 chain owns", int'(owns_bus), 1);
      run_cmd(10'h066, 1'b0, 1'b0, 1, 1'b1, 1'b0);
      chk_eq("R11 nostart ops", nops, 2);
      chk_eq("R11 nostart first op", int'(op_log[0]), 3);
      chk_eq("R11 nostart data", int'(byte_log[0]), 8'h30);
      chk_eq("R11 nostart status", int'(sts_code), 0);
   endtask

   task automatic t_hold;
      logic [2:0] c;
      c = sts_code;
      repeat (10) @(negedge clk);
      chk_eq("R13 done held", int'(sts_done), 1);
      chk_eq("R13 code held", int'(sts_code), int'(c));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write7();
      t_read7();
      t_write10();
      t_read10_invalid();
      t_read10_rstart();
      t_zero_len();
      t_addr_nack();
      t_data_nack();
      t_arb();
      t_idle_wait();
      t_stop_timeout();
      t_nostart();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule